// File: doc/BRIEF.md
# Arbitrated Device Status and Data Registers

This block holds the two 16-bit registers a simple character device presents on a system I/O bus: a status register whose top bit flags that a fresh character is waiting, and a data register that carries that character. Two parties write these registers. The bus side always wins: any bus read or write completes at once, and nothing the device is doing holds it up. The device engine must ask for each write. It raises a request for one register and holds its write data until it sees the grant pulse for that register.

The device engine offers only the values it owns. For the status register it supplies just the ready bit, and the block keeps bits 14:0 as they are. For the data register it supplies an 8-bit character, and the block stores it zero-extended. Registered strobes tell the engine when the bus has read or written each register. The engine uses the data-register read strobe to know when it should clear the ready bit.

Top module: `devreg_pair`

## Requirements
- R1: While `rst` is high at a clock edge, both registers, `bus_rdata`, both grants and all four strobes are zero on the next cycle.
- R2: A bus write (`bus_wr`=1) to address 0 (status) or 1 (data) stores `bus_wdata` in that register, visible on the cycle after the edge. The matching write strobe is high for exactly that one cycle.
- R3: A bus read (`bus_rd`=1) loads `bus_rdata` with the addressed register on the cycle after the edge, and the matching read strobe pulses for that cycle. `bus_rdata` holds its value when no read is made.
- R4: A device request for a register, made with no bus write to that register and no grant currently shown, is committed at the edge. On the next cycle the register shows the new value and that register's grant is high for exactly one cycle.
- R5: When a bus write and a device request target the same register in the same cycle, the bus value is stored and no grant is given that cycle.
- R6: A device write to the status register sets bit 15 to `dev_rdy` and leaves bits 14:0 unchanged.
- R7: A device write to the data register stores `dev_char` in bits 7:0 and zeros in bits 15:8.
- R8: A request held high gives grants on alternate cycles only (1,0,1,0...), so a grant never lasts two cycles.
- R9: A bus read and a bus write to the same register in one cycle return the old value on `bus_rdata` while the new value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Bus read enable |
| bus_wr | input | 1 | Bus write enable |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Registered bus read data |
| dev_st_req | input | 1 | Device request to write the status ready bit |
| dev_rdy | input | 1 | Ready-bit value for a device status write |
| dev_st_gnt | output | 1 | One-cycle grant for the status write |
| dev_dat_req | input | 1 | Device request to write the data register |
| dev_char | input | 8 | Character for a device data write |
| dev_dat_gnt | output | 1 | One-cycle grant for the data write |
| st_q | output | 16 | Current status register |
| dat_q | output | 16 | Current data register |
| st_rd_stb | output | 1 | Bus read of status seen |
| st_wr_stb | output | 1 | Bus write of status seen |
| dat_rd_stb | output | 1 | Bus read of data seen |
| dat_wr_stb | output | 1 | Bus write of data seen |

## Verification
The hardest situation to reach is a collision: a bus write and a device request aimed at the same register on the same edge, where the grant must stay low and the bus value must stick. The stimulus table schedules this case on purpose and sets it beside a bus write to the other register on the same edge as a device request. It also reads status on the same edge as a device status write, to show that the read returns the old value. Directed tests then hold a request high over several cycles to show the alternate-cycle grant pattern, and issue a read and a write to one register together.

// File: rtl/devreg_pkg.sv
package devreg_pkg;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam int NREG   = 2;
  localparam int ADDR_W = 1;
  typedef enum logic [ADDR_W-1:0] {SEL_STAT = 1'b0, SEL_DATA = 1'b1} reg_sel_e;
endpackage

// File: rtl/devreg_arb_cell.sv
module devreg_arb_cell #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_d,
  input  logic          dev_req,
  input  logic [DW-1:0] dev_d,
  output logic [DW-1:0] q,
  output logic          gnt,
  output logic          wr_stb,
  output logic          rd_stb
);
  logic dev_take;
  assign dev_take = dev_req && !bus_we && !gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      gnt    <= 1'b0;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
    end else begin
      wr_stb <= bus_we;
      rd_stb <= bus_re;
      gnt    <= dev_take;
      if (bus_we)        q <= bus_d;
      else if (dev_take) q <= dev_d;
    end
  end

  // R5
  bus_wins_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> (!gnt && q == $past(bus_d)));
  // R4
  gnt_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    gnt |-> $past(dev_req));
  // R8
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    gnt |=> !gnt);
endmodule

// File: rtl/devreg_rd_port.sv
module devreg_rd_port #(
  parameter int DW   = 16,
  parameter int NREG = 2,
  parameter int AW   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] regs [NREG],
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= regs[addr];
  end

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/devreg_pair.sv
module devreg_pair
  import devreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dev_st_req,
  input  logic              dev_rdy,
  output logic              dev_st_gnt,
  input  logic              dev_dat_req,
  input  logic [CHAR_W-1:0] dev_char,
  output logic              dev_dat_gnt,
  output logic [DATA_W-1:0] st_q,
  output logic [DATA_W-1:0] dat_q,
  output logic              st_rd_stb,
  output logic              st_wr_stb,
  output logic              dat_rd_stb,
  output logic              dat_wr_stb
);
  localparam int RDY_BIT = DATA_W - 1;
  localparam int PAD_W   = DATA_W - CHAR_W;

  logic [DATA_W-1:0] dev_d  [NREG];
  logic [DATA_W-1:0] q_arr  [NREG];
  logic              req    [NREG];
  logic              gnt    [NREG];
  logic              wstb   [NREG];
  logic              rstb   [NREG];

  assign dev_d[SEL_STAT] = {dev_rdy, q_arr[SEL_STAT][RDY_BIT-1:0]};
  assign dev_d[SEL_DATA] = {{PAD_W{1'b0}}, dev_char};
  assign req[SEL_STAT]   = dev_st_req;
  assign req[SEL_DATA]   = dev_dat_req;

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    devreg_arb_cell #(.DW(DATA_W)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .bus_we (bus_wr && (bus_addr == ADDR_W'(i))),
      .bus_re (bus_rd && (bus_addr == ADDR_W'(i))),
      .bus_d  (bus_wdata),
      .dev_req(req[i]),
      .dev_d  (dev_d[i]),
      .q      (q_arr[i]),
      .gnt    (gnt[i]),
      .wr_stb (wstb[i]),
      .rd_stb (rstb[i])
    );
  end

  devreg_rd_port #(.DW(DATA_W), .NREG(NREG), .AW(ADDR_W)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .rd   (bus_rd),
    .addr (bus_addr),
    .regs (q_arr),
    .rdata(bus_rdata)
  );

  assign st_q        = q_arr[SEL_STAT];
  assign dat_q       = q_arr[SEL_DATA];
  assign dev_st_gnt  = gnt[SEL_STAT];
  assign dev_dat_gnt = gnt[SEL_DATA];
  assign st_rd_stb   = rstb[SEL_STAT];
  assign st_wr_stb   = wstb[SEL_STAT];
  assign dat_rd_stb  = rstb[SEL_DATA];
  assign dat_wr_stb  = wstb[SEL_DATA];

  // R6
  st_low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    dev_st_gnt |-> (st_q[RDY_BIT-1:0] == $past(st_q[RDY_BIT-1:0])));
  // R7
  dat_pad_chk: assert property (@(posedge clk) disable iff (rst)
    dev_dat_gnt |-> (dat_q[DATA_W-1:CHAR_W] == '0));
endmodule

// File: tb/test_devreg_pair.sv
module test_devreg_pair;
  logic clk = 0;
  logic rst = 1;
  logic bus_addr = 0, bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic dev_st_req = 0, dev_rdy = 0, dev_st_gnt;
  logic dev_dat_req = 0, dev_dat_gnt;
  logic [7:0] dev_char = '0;
  logic [15:0] st_q, dat_q;
  logic st_rd_stb, st_wr_stb, dat_rd_stb, dat_wr_stb;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  devreg_pair i_devreg_pair (.*);

  // stimulus: addr, rd, wr, wdata[16], st_req, rdy, dat_req, char[8]
  localparam int NV = 10;
  localparam logic [29:0] STIM [NV] = '{
    {3'b000, 16'h0000, 3'b001, 8'h34},
    {3'b000, 16'h0000, 3'b110, 8'h00},
    {3'b110, 16'h0000, 3'b000, 8'h00},
    {3'b000, 16'h0000, 3'b100, 8'h00},
    {3'b001, 16'h1234, 3'b000, 8'h00},
    {3'b000, 16'h0000, 3'b110, 8'h00},
    {3'b101, 16'hBEEF, 3'b001, 8'h41},
    {3'b000, 16'h0000, 3'b001, 8'h41},
    {3'b010, 16'h0000, 3'b100, 8'h00},
    {3'b001, 16'h0F0F, 3'b001, 8'h7E}
  };
  // expected: st_q, dat_q, rdata, {sgnt,dgnt,srd,swr,drd,dwr}
  localparam logic [53:0] EXP [NV] = '{
    {16'h0000, 16'h0034, 16'h0000, 6'b010000},
    {16'h8000, 16'h0034, 16'h0000, 6'b100000},
    {16'h8000, 16'h0034, 16'h0034, 6'b000010},
    {16'h0000, 16'h0034, 16'h0034, 6'b100000},
    {16'h1234, 16'h0034, 16'h0034, 6'b000100},
    {16'h9234, 16'h0034, 16'h0034, 6'b100000},
    {16'h9234, 16'hBEEF, 16'h0034, 6'b000001},
    {16'h9234, 16'h0041, 16'h0034, 6'b010000},
    {16'h1234, 16'h0041, 16'h9234, 6'b101000},
    {16'h0F0F, 16'h007E, 16'h9234, 6'b010100}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] flags();
    return {dev_st_gnt, dev_dat_gnt, st_rd_stb, st_wr_stb, dat_rd_stb, dat_wr_stb};
  endfunction

  task automatic idle();
    {bus_addr, bus_rd, bus_wr} = 3'b000;
    bus_wdata = '0;
    {dev_st_req, dev_rdy, dev_dat_req} = 3'b000;
    dev_char = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: drive activity during reset, expect everything zero
    @(negedge clk);
    bus_wr = 1; bus_wdata = 16'hFFFF; dev_dat_req = 1; dev_char = 8'hAA; bus_rd = 1;
    repeat (3) @(negedge clk);
    chk("R1 st_q", st_q, 0);
    chk("R1 dat_q", dat_q, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 flags", flags(), 0);
    idle();
    rst = 0;
    @(negedge clk);

    // table walk (R2 R3 R4 R5 R6 R7)
    for (int v = 0; v < NV; v++) begin
      {bus_addr, bus_rd, bus_wr, bus_wdata, dev_st_req, dev_rdy, dev_dat_req, dev_char} = STIM[v];
      @(negedge clk);
      chk($sformatf("R2 R4 R6 st_q v%0d", v), st_q, EXP[v][53:38]);
      chk($sformatf("R2 R5 R7 dat_q v%0d", v), dat_q, EXP[v][37:22]);
      chk($sformatf("R3 R9 rdata v%0d", v), bus_rdata, EXP[v][21:6]);
      chk($sformatf("R2 R3 R4 R5 flags v%0d", v), flags(), EXP[v][5:0]);
    end
    idle();
    @(negedge clk);

    // R8: held request grants on alternate cycles
    dev_dat_req = 1; dev_char = 8'h55;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk($sformatf("R8 gnt c%0d", c), dev_dat_gnt, (c % 2 == 0) ? 1 : 0);
    end
    chk("R8 R7 dat_q", dat_q, 16'h0055);
    idle();
    @(negedge clk);

    // R9: read and write same register together
    bus_addr = 1; bus_rd = 1; bus_wr = 1; bus_wdata = 16'hC0DE;
    @(negedge clk);
    chk("R9 rdata old", bus_rdata, 16'h0055);
    chk("R9 dat_q new", dat_q, 16'hC0DE);
    chk("R9 strobes", flags(), 6'b000011);
    idle();
    @(negedge clk);
    chk("R2 R3 strobes drop", flags(), 0);
    chk("R3 rdata hold", bus_rdata, 16'h0055);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule